// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor that finishes each instruction in one clock period. In that period it fetches the word at the program counter, decodes it, reads two source registers, computes a result, optionally reads or writes data memory, and writes back. It supports three-register add and subtract, OR with a 16-bit immediate, word load, word store, and conditional branch on equality. The branch compares the two registers by subtracting them and testing the result for zero.

The instruction store and the data store are small word arrays inside the core. Reads from both are combinational, and the data store is written on the clock edge. A test environment loads the program by writing the instruction array directly. The core exposes its program counter, its register write port and its data store write port, so that every architectural effect can be observed from outside.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the program counter is 0 and both `rf_we_o` and `dm_we_o` are low. Reset is synchronous. After reset, all 32 registers read as 0.
- R2: An instruction with op[31:26]=0x00 and funct[5:0]=0x21 writes rs+rt into register rd, modulo 2^32. With funct 0x23 it writes rs−rt. Here rs=[25:21], rt=[20:16] and rd=[15:11].
- R3: op 0x0D writes rs OR {16'h0, imm[15:0]} into register rt. The upper 16 bits of the result equal rs.
- R4: op 0x23 writes the data word at byte address rs+sign_ext(imm) into register rt. The word index is address bits [DW+1:2].
- R5: op 0x2B asserts `dm_we_o` with `dm_addr_o` = rs+sign_ext(imm) and `dm_wdata_o` = rt, and stores that word. It writes no register.
- R6: op 0x04 sets the PC to PC+4+(sign_ext(imm)<<2) when rs equals rt, and to PC+4 otherwise. Negative offsets branch backward.
- R7: Register 0 always reads as 0. An instruction that names it as destination does not raise `rf_we_o` and leaves it 0.
- R8: Any other op value, or op 0x00 with a funct other than 0x21 or 0x23, writes nothing and only advances the PC by 4.
- R9: Each instruction other than a taken branch advances the PC by exactly 4 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write happens at the coming edge |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value being written back |
| dm_we_o | output | 1 | Data store write happens at the coming edge |
| dm_addr_o | output | 32 | Computed data byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
The program first builds operands with immediates of both polarities. The all-ones immediate separates zero extension from sign extension. An unsigned underflow in the subtract exposes a wrong operand order or a signed compare. Stores and loads use both negative and positive offsets from a base register, and the loads read back earlier stores, which shows that the address add and the word indexing agree. Branches are tried not taken, taken forward over instructions that would otherwise write, taken backward as a counted loop, and as a self-loop. Writes aimed at register 0 and undefined opcodes or functs check that nothing changes. A behavioural model compares the PC and both write ports on every cycle.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int IW = $clog2(IMEM_WORDS);
  localparam int DW = $clog2(DMEM_WORDS);
  localparam logic [5:0] OP_RT = 6'h00, OP_ORI = 6'h0D, OP_LW = 6'h23,
                         OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADD = 6'h21, FN_SUB = 6'h23;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];
  logic [31:0] pc, instr;

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  assign instr = imem[pc[IW+1:2]];

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic        unused_shamt;
  assign op  = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign fn  = instr[5:0];
  assign imm = instr[15:0];
  assign unused_shamt = ^instr[10:6];

  logic is_add, is_sub, is_ori, is_lw, is_sw, is_beq;
  assign is_add = (op == OP_RT) && (fn == FN_ADD);
  assign is_sub = (op == OP_RT) && (fn == FN_SUB);
  assign is_ori = (op == OP_ORI);
  assign is_lw  = (op == OP_LW);
  assign is_sw  = (op == OP_SW);
  assign is_beq = (op == OP_BEQ);

  logic [31:0] bus_a, bus_b, sext, ext, alu_b, alu_res, wb_data;
  logic        alu_zero, wr_en;
  logic [4:0]  wr_reg;

  assign bus_a = (rs == 5'd0) ? '0 : regs[rs];
  assign bus_b = (rt == 5'd0) ? '0 : regs[rt];
  assign sext  = {{16{imm[15]}}, imm};
  assign ext   = is_ori ? {16'h0, imm} : sext;
  assign alu_b = (is_ori || is_lw || is_sw) ? ext : bus_b;

  always_comb begin
    if (is_ori)                alu_res = bus_a | alu_b;
    else if (is_sub || is_beq) alu_res = bus_a - alu_b;
    else                       alu_res = bus_a + alu_b;
  end
  assign alu_zero = (alu_res == '0);

  assign wr_reg  = (op == OP_RT) ? rd : rt;
  assign wb_data = is_lw ? dmem[alu_res[DW+1:2]] : alu_res;
  assign wr_en   = !rst && (is_add || is_sub || is_ori || is_lw) && (wr_reg != 5'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && is_sw) dmem[alu_res[DW+1:2]] <= bus_b;
  end

  logic [31:0] pc_inc, pc_next;
  assign pc_inc  = pc + 32'd4;
  assign pc_next = (is_beq && alu_zero) ? pc_inc + {sext[29:0], 2'b00} : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_o       = pc;
  assign rf_we_o    = wr_en;
  assign rf_waddr_o = wr_reg;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = !rst && is_sw;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = bus_b;

  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    !is_beq |=> pc == $past(pc) + 32'd4);

  p_branch_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (is_beq && bus_a == bus_b) |=> pc == $past(pc) + 32'd4 + {$past(sext[29:0]), 2'b00});

  p_branch_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (is_beq && bus_a != bus_b) |=> pc == $past(pc) + 32'd4);

  p_no_reg0_write_r7: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_waddr_o != 5'd0);

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o);

  p_ori_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (is_ori && rf_we_o) |-> rf_wdata_o[31:16] == bus_a[31:16]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int IW = 64;
  localparam int DW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
    .clk(clk), .rst(rst), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o));

  logic [31:0] prog [IW];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DW];
  logic [31:0] mpc;

  function automatic logic [31:0] rtype(int s, int t, int d, logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] o, int s, int t, int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [31:0] w);
    case (w[31:26])
      6'h00: return (w[5:0] == 6'h21 || w[5:0] == 6'h23) ?
               ((w[15:11] == 5'd0) ? "R7" : "R2") : "R8";
      6'h0D: return "R3";
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h04: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic step_model();
    logic [31:0] w, a, b, se, res, npc;
    logic we, sw;
    logic [4:0] wr;
    string t;
    w  = prog[(mpc >> 2) % IW];
    a  = mreg[w[25:21]];
    b  = mreg[w[20:16]];
    se = {{16{w[15]}}, w[15:0]};
    we = 1'b0; sw = 1'b0; wr = w[20:16]; res = 32'h0;
    npc = mpc + 4;
    t = tag_of(w);
    case (w[31:26])
      6'h00: begin
        wr = w[15:11];
        if (w[5:0] == 6'h21) begin we = 1'b1; res = a + b; end
        else if (w[5:0] == 6'h23) begin we = 1'b1; res = a - b; end
      end
      6'h0D: begin we = 1'b1; res = a | {16'h0, w[15:0]}; end
      6'h23: begin we = 1'b1; res = mdm[((a + se) >> 2) % DW]; end
      6'h2B: begin sw = 1'b1; res = a + se; end
      6'h04: if (a == b) npc = mpc + 4 + (se << 2);
      default: ;
    endcase
    if (wr == 5'd0) we = 1'b0;
    chk((w[31:26] == 6'h04) ? "R6" : "R9", "pc", pc_o, mpc);
    chk(t, "rf_we", {31'h0, rf_we_o}, {31'h0, we});
    if (we) begin
      chk(t, "rf_waddr", {27'h0, rf_waddr_o}, {27'h0, wr});
      chk(t, "rf_wdata", rf_wdata_o, res);
    end
    chk(t, "dm_we", {31'h0, dm_we_o}, {31'h0, sw});
    if (sw) begin
      chk("R5", "dm_addr", dm_addr_o, res);
      chk("R5", "dm_wdata", dm_wdata_o, b);
      mdm[(res >> 2) % DW] = b;
    end
    if (we) mreg[wr] = res;
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = itype(6'h0D, 0, 1, 16'h1234);
    prog[1]  = itype(6'h0D, 0, 2, 16'hFFFF);
    prog[2]  = rtype(1, 2, 3, 6'h21);
    prog[3]  = rtype(1, 2, 4, 6'h23);
    prog[4]  = itype(6'h0D, 0, 7, 16);
    prog[5]  = itype(6'h2B, 0, 4, 8);
    prog[6]  = itype(6'h2B, 7, 3, -4);
    prog[7]  = itype(6'h23, 7, 5, -8);
    prog[8]  = itype(6'h23, 0, 6, 12);
    prog[9]  = rtype(1, 2, 0, 6'h21);
    prog[10] = rtype(0, 1, 9, 6'h21);
    prog[11] = itype(6'h04, 1, 2, 5);
    prog[12] = itype(6'h04, 9, 1, 2);
    prog[13] = itype(6'h0D, 0, 10, 16'hAAAA);
    prog[14] = itype(6'h0D, 0, 10, 16'hBBBB);
    prog[15] = 32'hFC00_0000;
    prog[16] = rtype(1, 2, 13, 6'h20);
    prog[17] = itype(6'h0D, 0, 11, 2);
    prog[18] = itype(6'h0D, 0, 12, 1);
    prog[19] = rtype(11, 12, 11, 6'h23);
    prog[20] = itype(6'h04, 11, 0, 1);
    prog[21] = itype(6'h04, 0, 0, -3);
    prog[22] = itype(6'h2B, 0, 11, 0);
    prog[23] = rtype(0, 0, 14, 6'h21);
    prog[24] = itype(6'h04, 0, 0, -1);
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    for (int i = 0; i < DW; i++) mdm[i] = 32'h0;
    mpc = 32'h0;
    #1;
    for (int i = 0; i < IW; i++) uut.imem[i] = prog[i];
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", pc_o, 32'h0);
    chk("R1", "reset rf_we", {31'h0, rf_we_o}, 32'h0);
    chk("R1", "reset dm_we", {31'h0, dm_we_o}, 32'h0);
    rst = 1'b0;
    for (int c = 0; c < 45; c++) begin
      #1;
      step_model();
      @(negedge clk);
    end
    // R7: r14 = r0 + r0 was written after the ignored write to r0
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule